// File: doc/BRIEF.md
# Periodic Interval Timer with Queued Interrupts

The block divides the system clock down to a fixed 100 Hz tick with a prescaler. On each tick it counts down from a programmable reload value. When the count runs out, it records one expiry and reloads itself. Expiries are not merged. Each one adds to a small pending counter, and the interrupt request line stays high for as long as that counter is nonzero.

Software controls the block through two word registers. The reload register sets the period in ticks. The status register is used to acknowledge. Any access to the status register, read or write, retires one pending expiry and restarts the current count from the reload value. A read of the status register also returns the count as it stood just before that restart. The timer runs only while its external enable input is high and the reload value is nonzero.

Top module: `periodic_irq_timer`

## Requirements
- R1: After reset, `irq` is low, and both the reload value and the current count read as zero.
- R2: A write with `acc_addr`=0 loads `acc_wdata` into both the reload value and the current count, and restarts the prescaler. With `acc_addr`=0, `rdata` returns the reload value.
- R3: The count, the prescaler and the pending counter do not advance while `en` is low or while the reload value is zero.
- R4: With reload value N, the first expiry lands N*`DIV` cycles after the reload write. The count then reloads itself in that same cycle, so expiries repeat every N*`DIV` cycles.
- R5: Each expiry increments the pending counter, and `irq` is high exactly while the pending counter is nonzero.
- R6: Any access with `acc_addr`=1, read or write, decrements the pending counter if it is nonzero and reloads the count from the reload value. Write data to this address is ignored.
- R7: With `acc_addr`=1, `rdata` shows the current count, which is the value in effect before the reload that the access causes.
- R8: The pending counter stops at its maximum value, 2^`PEND_W`-1, and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Timer enable |
| acc_valid | input | 1 | Register access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 1 | 0 = reload register, 1 = status/acknowledge register |
| acc_wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data for the addressed register (combinational) |
| irq | output | 1 | Interrupt request, high while expiries are pending |

## Verification
A register write takes effect at the clock edge that samples it. `rdata` follows the address combinationally, so the bench samples it one time step after driving a read, before that edge. `irq` is registered behind the pending counter, so it rises at exactly the edge numbered N*`DIV` after the reload write, and it falls at the edge of the acknowledge that empties the counter. The bench drives inputs on the falling edge and counts whole cycles from the write, checking `irq` one cycle before and at the due edge. It retimes expected expiries after each acknowledge from the prescaler phase, which keeps running.

// File: rtl/periodic_irq_timer.sv
module periodic_irq_timer #(
  parameter int CNT_W  = 16,
  parameter int PEND_W = 4,
  parameter int DIV    = 1_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic             acc_addr,
  input  logic [CNT_W-1:0] acc_wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             irq
);
  localparam int PRE_W = $clog2(DIV + 1);
  localparam logic [PRE_W-1:0]  PRE_LAST = PRE_W'(DIV - 1);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic [CNT_W-1:0]  reload_q, count_q;
  logic [PEND_W-1:0] pend_q;
  logic [PRE_W-1:0]  presc_q;

  wire wr_reload = acc_valid & acc_write & ~acc_addr;
  wire ack       = acc_valid & acc_addr;
  wire run       = en & (|reload_q);
  wire tick      = run & (presc_q == PRE_LAST);
  wire expire    = tick & (count_q <= CNT_W'(1));
  wire pend_dec  = ack & (|pend_q);
  wire pend_inc  = expire & (pend_q != PEND_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    presc_q <= '0;
    else if (!run || wr_reload || tick) presc_q <= '0;
    else                           presc_q <= presc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reload_q <= '0;
    else if (wr_reload) reload_q <= acc_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count_q <= '0;
    else if (wr_reload)      count_q <= acc_wdata;
    else if (ack || expire)  count_q <= reload_q;
    else if (tick)           count_q <= count_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    pend_q <= '0;
    else if (expire && !pend_dec)  pend_q <= pend_inc ? pend_q + 1'b1 : pend_q;
    else if (pend_dec && !expire)  pend_q <= pend_q - 1'b1;
  end

  assign rdata = acc_addr ? count_q : reload_q;
  assign irq   = |pend_q;
endmodule

module periodic_irq_timer_chk #(
  parameter int CNT_W  = 16,
  parameter int PEND_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              acc_valid,
  input logic              acc_write,
  input logic              acc_addr,
  input logic [CNT_W-1:0]  acc_wdata,
  input logic              irq,
  input logic [CNT_W-1:0]  reload_q,
  input logic [CNT_W-1:0]  count_q,
  input logic [PEND_W-1:0] pend_q,
  input logic              expire
);
  AST_RELOAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_write && !acc_addr |=> reload_q == $past(acc_wdata) && count_q == $past(acc_wdata)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || reload_q == '0) && !acc_valid |=> $stable(count_q) && $stable(pend_q)); // R3
  AST_EXPIRE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !acc_valid |=> irq); // R5
  AST_ACK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_addr |=> count_q == $past(reload_q)); // R6
  AST_ACK_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_addr && !expire && pend_q != '0 |=> pend_q == $past(pend_q) - 1'b1); // R6
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q == '1 && !acc_valid |=> pend_q == '1); // R8
endmodule

bind periodic_irq_timer periodic_irq_timer_chk #(.CNT_W(CNT_W), .PEND_W(PEND_W)) chk (
  .clk(clk), .rst_n(rst_n), .en(en), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_addr(acc_addr), .acc_wdata(acc_wdata), .irq(irq), .reload_q(reload_q),
  .count_q(count_q), .pend_q(pend_q), .expire(expire)
);

// File: tb/periodic_irq_timer_test.sv
module periodic_irq_timer_test;
  localparam int CW = 16;
  localparam int DIV = 4;

  logic clk = 0, rst_n = 0, en = 0;
  logic acc_valid = 0, acc_write = 0, acc_addr = 0;
  logic [CW-1:0] acc_wdata = '0;
  logic [CW-1:0] rdata;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  periodic_irq_timer #(.CNT_W(CW), .PEND_W(2), .DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rdata(rdata), .irq(irq));

  always #5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic access(logic wr, logic addr, logic [CW-1:0] d, output logic [CW-1:0] rd);
    acc_valid = 1; acc_write = wr; acc_addr = addr; acc_wdata = d;
    #1 rd = rdata;
    @(posedge clk); @(negedge clk);
    acc_valid = 0; acc_write = 0; acc_wdata = '0;
  endtask

  task automatic t_reset();
    logic [CW-1:0] r;
    chk("R1 irq", irq, 0);
    access(0, 0, '0, r); chk("R1 reload", r, 0);
    access(0, 1, '0, r); chk("R1 count", r, 0);
  endtask

  task automatic t_idle();
    logic [CW-1:0] r;
    en = 0;
    access(1, 0, 16'd2, r);
    wait_cyc(40);
    chk("R3 disabled irq", irq, 0);
    access(0, 0, '0, r); chk("R2 reload readback", r, 2);
    access(0, 1, '0, r); chk("R3 disabled count", r, 2);
    en = 1;
    access(1, 0, 16'd0, r);
    wait_cyc(40);
    chk("R3 zero reload irq", irq, 0);
    access(0, 1, '0, r); chk("R3 zero reload count", r, 0);
  endtask

  task automatic t_period();
    logic [CW-1:0] r;
    en = 1;
    access(1, 0, 16'd3, r);
    wait_cyc(11); chk("R4 before first expiry", irq, 0);
    wait_cyc(1);  chk("R5 first expiry", irq, 1);
    access(0, 1, '0, r); chk("R6 ack clears", irq, 0);
    wait_cyc(10); chk("R4 before second expiry", irq, 0);
    wait_cyc(1);  chk("R4 second expiry", irq, 1);
    en = 0;
    access(0, 1, '0, r); chk("R6 cleanup", irq, 0);
  endtask

  task automatic t_queue();
    logic [CW-1:0] r;
    en = 1;
    access(1, 0, 16'd3, r);
    wait_cyc(36);
    en = 0;
    chk("R5 queued irq", irq, 1);
    access(0, 1, '0, r); chk("R5 after ack 1", irq, 1);
    access(1, 1, 16'h7, r); chk("R6 after write-ack 2", irq, 1);
    access(0, 1, '0, r); chk("R5 after ack 3", irq, 0);
    access(0, 1, '0, r); chk("R6 write data ignored", r, 3);
    chk("R6 ack on empty", irq, 0);
  endtask

  task automatic t_readcount();
    logic [CW-1:0] r;
    en = 1;
    access(1, 0, 16'd5, r);
    wait_cyc(9);
    access(0, 1, '0, r); chk("R7 count before reload", r, 3);
    access(0, 1, '0, r); chk("R6 count reloaded", r, 5);
    chk("R6 no spurious irq", irq, 0);
    en = 0;
  endtask

  task automatic t_saturate();
    logic [CW-1:0] r;
    en = 1;
    access(1, 0, 16'd1, r);
    wait_cyc(21);
    en = 0;
    access(0, 1, '0, r); chk("R8 after ack 1", irq, 1);
    access(0, 1, '0, r); chk("R8 after ack 2", irq, 1);
    access(0, 1, '0, r); chk("R8 after ack 3", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_period();
    t_queue();
    t_readcount();
    t_saturate();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule